// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking descriptor tables held in memory. A walk begins at a context table. The block locates it from a configured table pointer and a context number. From there it descends through up to three further levels of descriptors. At the first or second level a walk may stop early on a large-page entry. Reads go out one 32-bit word at a time over a request/ready port, and only one access is ever outstanding.

Once a walk succeeds, the block marks the final entry as accessed. On a write access it also marks the entry as modified. If either mark changed, the updated entry is stored back to the word it came from. A single-cycle done pulse returns the physical address, the final entry and an error code. When translation is disabled, the virtual address passes straight through and memory is not touched.

Top module: `pagewalk_unit`

## Requirements
- R1: With `cfg_enable` low when `start` is sampled, `done` pulses one cycle later with `paddr` equal to `vaddr`, `err` 0 and `full_access` 1, and no memory request is made.
- R2: The first word read by an enabled walk is at address (`cfg_root` << 4) + (`cfg_ctx` << 4), truncated to 32 bits.
- R3: Bits [1:0] of a fetched entry give its type: 0 invalid, 1 table pointer, 2 page, 3 reserved. Entries are big-endian on the bus: entry bits [31:24] travel on bus bits [7:0] and entry bits [7:0] on bus bits [31:24], in both directions.
- R4: An invalid entry ends the walk with `err` 1. A reserved entry, a page entry in the context table, or a table pointer at the third level ends it with `err` 4.
- R5: A table pointer at context, first or second level sends the next read to ((entry with bits [1:0] cleared) << 4) + 4×index, truncated to 32 bits. The index is VA[31:24], VA[23:18] or VA[17:12] respectively.
- R6: A page entry at level 1, 2 or 3 gives `paddr` = (entry[31:8] << 12, truncated to 32 bits) + offset. The offset is VA[23:0], VA[17:0] or VA[11:0] respectively.
- R7: On success `pte_out` is the fetched entry with bit 5 (accessed) set, and with bit 6 (modified) also set when `is_write` was high. Exactly one write of that value to the entry's own address follows when it differs from the fetched entry; otherwise no write is made.
- R8: Each request holds `mem_req`, `mem_addr` and `mem_we` steady until the cycle in which `mem_rdy` is high.
- R9: `done` is a single-cycle pulse. It falls low after reset, and the results stay held until the next walk ends.
- R10: A faulting walk returns `paddr` 0, `pte_out` equal to the entry that faulted, and `full_access` 0, and it makes no write.
- R11: `full_access` is 1 only after a bypassed walk; every enabled walk returns it as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Translation enable, sampled at start |
| cfg_root | input | ROOT_W (28) | Context table pointer, in 16-byte units |
| cfg_ctx | input | CTX_W (8) | Context number |
| start | input | 1 | Launch a walk (taken only when idle) |
| vaddr | input | 32 | Virtual address to translate |
| is_write | input | 1 | Access is a write |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write-back |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Write data, bus byte order |
| mem_rdy | input | 1 | Memory accepts / returns data this cycle |
| mem_rdata | input | 32 | Read data, bus byte order, valid with `mem_rdy` |
| done | output | 1 | Walk finished (one cycle) |
| paddr | output | 32 | Physical address |
| pte_out | output | 32 | Final entry (updated on success) |
| err | output | 3 | 0 ok, 1 invalid entry, 4 bad entry type |
| full_access | output | 1 | Bypass result: read and write both allowed |

## Verification
The assertions assume that the memory never raises `mem_rdy` while no request is pending. They also assume that `start` comes only while the walker is idle, so that results are read between walks. The stimulus keeps to both. Its memory model asserts ready only against a live request, after a latency of zero to two cycles. The bench waits for each `done` before it issues the next `start`. It sweeps every first-level index over mixed tables of all four entry types and over several contexts, for reads and writes. The stores that one walk makes are seen by the walks after it.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned ACC_BIT = 5;
  localparam int unsigned MOD_BIT = 6;

  typedef enum logic [1:0] {
    ET_INVALID = 2'd0,
    ET_TABLE   = 2'd1,
    ET_PAGE    = 2'd2,
    ET_RSVD    = 2'd3
  } ent_kind_e;

  typedef enum logic [1:0] {
    STEP_DESCEND,
    STEP_LEAF,
    STEP_FAULT
  } step_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WBACK
  } walk_st_e;

  localparam logic [2:0] ERR_NONE    = 3'd0;
  localparam logic [2:0] ERR_INVALID = 3'd1;
  localparam logic [2:0] ERR_BADTYPE = 3'd4;
endpackage

// File: rtl/pw_bswap.sv
module pw_bswap #(
  parameter int unsigned BYTES = 4,
  parameter bit          SWAP  = 1'b1
) (
  input  logic [8*BYTES-1:0] din,
  output logic [8*BYTES-1:0] dout
);
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    if (SWAP) begin : g_rev
      assign dout[8*b +: 8] = din[8*(BYTES-1-b) +: 8];
    end else begin : g_pass
      assign dout[8*b +: 8] = din[8*b +: 8];
    end
  end
endmodule

// File: rtl/pw_step.sv
module pw_step
  import pw_pkg::*;
(
  input  logic [WORD_W-1:0] entry,
  input  logic [1:0]        level,
  input  logic [WORD_W-1:0] va,
  output step_e             kind,
  output logic [2:0]        err_code,
  output logic [WORD_W-1:0] next_addr,
  output logic [WORD_W-1:0] leaf_pa
);
  logic [WORD_W-1:0] tbl_base;
  logic [WORD_W-1:0] tbl_index;
  logic [WORD_W-1:0] page_base;
  logic [WORD_W-1:0] page_off;

  always_comb begin
    tbl_base  = {entry[WORD_W-1:2], 2'b00} << 4;
    page_base = {entry[WORD_W-1:8], 8'h00} << 4;
    case (level)
      2'd0:    tbl_index = {22'd0, va[31:24], 2'b00};
      2'd1:    tbl_index = {24'd0, va[23:18], 2'b00};
      2'd2:    tbl_index = {24'd0, va[17:12], 2'b00};
      default: tbl_index = '0;
    endcase
    case (level)
      2'd1:    page_off = {8'd0,  va[23:0]};
      2'd2:    page_off = {14'd0, va[17:0]};
      default: page_off = {20'd0, va[11:0]};
    endcase
    next_addr = tbl_base + tbl_index;
    leaf_pa   = page_base + page_off;
  end

  always_comb begin
    kind     = STEP_FAULT;
    err_code = ERR_BADTYPE;
    case (ent_kind_e'(entry[1:0]))
      ET_INVALID: err_code = ERR_INVALID;
      ET_TABLE: if (level != 2'd3) begin
        kind     = STEP_DESCEND;
        err_code = ERR_NONE;
      end
      ET_PAGE: if (level != 2'd0) begin
        kind     = STEP_LEAF;
        err_code = ERR_NONE;
      end
      default: err_code = ERR_BADTYPE;
    endcase
  end
endmodule

// File: rtl/pw_flag_update.sv
module pw_flag_update
  import pw_pkg::*;
(
  input  logic [WORD_W-1:0] entry,
  input  logic              wr_access,
  output logic [WORD_W-1:0] updated,
  output logic              changed
);
  always_comb begin
    updated          = entry;
    updated[ACC_BIT] = 1'b1;
    if (wr_access) updated[MOD_BIT] = 1'b1;
    changed = (updated != entry);
  end
endmodule

// File: rtl/pagewalk_unit.sv
module pagewalk_unit
  import pw_pkg::*;
#(
  parameter int unsigned ROOT_W     = 28,
  parameter int unsigned CTX_W      = 8,
  parameter bit          BIG_ENDIAN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic [ROOT_W-1:0] cfg_root,
  input  logic [CTX_W-1:0]  cfg_ctx,
  input  logic              start,
  input  logic [31:0]       vaddr,
  input  logic              is_write,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_rdy,
  input  logic [31:0]       mem_rdata,
  output logic              done,
  output logic [31:0]       paddr,
  output logic [31:0]       pte_out,
  output logic [2:0]        err,
  output logic              full_access
);
  localparam int unsigned BYTES = WORD_W / 8;

  walk_st_e          st_q, st_d;
  logic [1:0]        lvl_q, lvl_d;
  logic [WORD_W-1:0] addr_q, addr_d;
  logic [WORD_W-1:0] va_q, va_d;
  logic              wr_q, wr_d;
  logic              done_q, done_d;
  logic [WORD_W-1:0] pa_q, pa_d;
  logic [WORD_W-1:0] pte_q, pte_d;
  logic [2:0]        err_q, err_d;
  logic              full_q, full_d;
  logic              res_ld;

  logic [WORD_W-1:0] rd_entry;
  logic [WORD_W-1:0] ctx_addr;
  step_e             step_kind;
  logic [2:0]        step_err;
  logic [WORD_W-1:0] step_next;
  logic [WORD_W-1:0] step_pa;
  logic [WORD_W-1:0] upd_entry;
  logic              upd_changed;

  pw_bswap #(.BYTES(BYTES), .SWAP(BIG_ENDIAN)) u_rd_swap (
    .din (mem_rdata),
    .dout(rd_entry)
  );

  pw_bswap #(.BYTES(BYTES), .SWAP(BIG_ENDIAN)) u_wr_swap (
    .din (pte_q),
    .dout(mem_wdata)
  );

  pw_step u_step (
    .entry    (rd_entry),
    .level    (lvl_q),
    .va       (va_q),
    .kind     (step_kind),
    .err_code (step_err),
    .next_addr(step_next),
    .leaf_pa  (step_pa)
  );

  pw_flag_update u_flags (
    .entry    (rd_entry),
    .wr_access(wr_q),
    .updated  (upd_entry),
    .changed  (upd_changed)
  );

  assign ctx_addr = WORD_W'({cfg_root, 4'b0000}) + WORD_W'({cfg_ctx, 4'b0000});

  always_comb begin
    st_d   = st_q;
    lvl_d  = lvl_q;
    addr_d = addr_q;
    va_d   = va_q;
    wr_d   = wr_q;
    done_d = 1'b0;
    pa_d   = pa_q;
    pte_d  = pte_q;
    err_d  = err_q;
    full_d = full_q;
    res_ld = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        va_d = vaddr;
        wr_d = is_write;
        if (cfg_enable) begin
          st_d   = ST_FETCH;
          lvl_d  = 2'd0;
          addr_d = ctx_addr;
        end else begin
          done_d = 1'b1;
          res_ld = 1'b1;
          pa_d   = vaddr;
          pte_d  = '0;
          err_d  = ERR_NONE;
          full_d = 1'b1;
        end
      end
      ST_FETCH: if (mem_rdy) begin
        case (step_kind)
          STEP_DESCEND: begin
            addr_d = step_next;
            lvl_d  = lvl_q + 2'd1;
          end
          STEP_LEAF: begin
            res_ld = 1'b1;
            pa_d   = step_pa;
            pte_d  = upd_entry;
            err_d  = ERR_NONE;
            full_d = 1'b0;
            if (upd_changed) begin
              st_d = ST_WBACK;
            end else begin
              st_d   = ST_IDLE;
              done_d = 1'b1;
            end
          end
          default: begin
            res_ld = 1'b1;
            pa_d   = '0;
            pte_d  = rd_entry;
            err_d  = step_err;
            full_d = 1'b0;
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end
        endcase
      end
      ST_WBACK: if (mem_rdy) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      lvl_q  <= 2'd0;
      addr_q <= '0;
      va_q   <= '0;
      wr_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      lvl_q  <= lvl_d;
      addr_q <= addr_d;
      va_q   <= va_d;
      wr_q   <= wr_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q   <= '0;
      pte_q  <= '0;
      err_q  <= ERR_NONE;
      full_q <= 1'b0;
    end else if (res_ld) begin
      pa_q   <= pa_d;
      pte_q  <= pte_d;
      err_q  <= err_d;
      full_q <= full_d;
    end
  end

  assign mem_req     = (st_q != ST_IDLE);
  assign mem_we      = (st_q == ST_WBACK);
  assign mem_addr    = addr_q;
  assign done        = done_q;
  assign paddr       = pa_q;
  assign pte_out     = pte_q;
  assign err         = err_q;
  assign full_access = full_q;
endmodule

// File: rtl/pw_checker.sv
module pw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic        mem_rdy,
  input logic        done,
  input logic [31:0] paddr,
  input logic [31:0] pte_out,
  input logic [2:0]  err,
  input logic        full_access
);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R4
  err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err == 3'd0 || err == 3'd1 || err == 3'd4));

  // R7
  acc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err == 3'd0 && !full_access) |-> pte_out[5]);

  // R10
  fault_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err != 3'd0) |-> (paddr == 32'd0 && !full_access));

  // R1
  bypass_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && full_access) |-> (err == 3'd0));
endmodule

bind pagewalk_unit pw_checker u_pw_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_rdy    (mem_rdy),
  .done       (done),
  .paddr      (paddr),
  .pte_out    (pte_out),
  .err        (err),
  .full_access(full_access)
);

// File: tb/tb_pagewalk_unit.sv
`timescale 1ns/1ps
module tb_pagewalk_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_enable;
  logic [27:0] cfg_root;
  logic [7:0]  cfg_ctx;
  logic        start;
  logic [31:0] vaddr;
  logic        is_write;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_rdy;
  logic [31:0] mem_rdata;
  logic        done;
  logic [31:0] paddr, pte_out;
  logic [2:0]  err;
  logic        full_access;

  always #2.5 clk = ~clk;

  pagewalk_unit dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_root(cfg_root),
    .cfg_ctx(cfg_ctx), .start(start), .vaddr(vaddr), .is_write(is_write),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdy(mem_rdy), .mem_rdata(mem_rdata), .done(done), .paddr(paddr),
    .pte_out(pte_out), .err(err), .full_access(full_access)
  );

  int vectors = 0;
  int fails   = 0;

  logic [31:0] mem [0:4095];
  logic        rdy_drv = 1'b0;
  logic        cap_we;
  logic [31:0] cap_addr, cap_wdata;
  int          wait_cnt = 0;
  int          lat_seed = 0;
  int          rd_cnt, wr_cnt, req_cnt;
  logic        first_pending;
  logic [31:0] first_addr;

  assign mem_rdy = rdy_drv;

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [31:0] rd_word(input logic [31:0] a);
    return bswap(mem[a[13:2]]);
  endfunction

  // memory model, acts between clock edges
  always @(negedge clk) begin
    if (rdy_drv) begin
      if (cap_we) begin
        mem[cap_addr[13:2]] = cap_wdata;
        wr_cnt++;
      end else rd_cnt++;
      rdy_drv = 1'b0;
    end
    if (mem_req) req_cnt++;
    if (mem_req && !rdy_drv) begin
      if (wait_cnt == 0) begin
        rdy_drv   = 1'b1;
        cap_we    = mem_we;
        cap_addr  = mem_addr;
        cap_wdata = mem_wdata;
        if (first_pending) begin
          first_addr    = mem_addr;
          first_pending = 1'b0;
        end
        mem_rdata = mem[mem_addr[13:2]];
        lat_seed++;
        wait_cnt = lat_seed % 3;
      end else wait_cnt--;
    end
  end

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // reference walk, worked out from the requirements
  task automatic ref_walk(input logic [31:0] va, input bit we, input logic [27:0] root,
                          input logic [7:0] ctx,
                          output logic [31:0] pa, output logic [31:0] pte,
                          output logic [2:0] e, output int nrd, output int nwr,
                          output logic [31:0] fa, output logic [31:0] wba,
                          output logic [31:0] wbv);
    logic [31:0] a, w, nw, mask;
    int lv;
    bit fin;
    a = {root, 4'h0} + {20'd0, ctx, 4'h0};
    fa = a; lv = 0; fin = 0; nrd = 0; nwr = 0; pa = 0; pte = 0; e = 0; wba = 0; wbv = 0;
    for (int s = 0; s < 4; s++) begin
      if (!fin) begin
        w = rd_word(a); nrd++;
        if (w[1:0] == 2'd0) begin e = 3'd1; pte = w; fin = 1; end
        else if (w[1:0] == 2'd3) begin e = 3'd4; pte = w; fin = 1; end
        else if (w[1:0] == 2'd1) begin
          if (lv == 3) begin e = 3'd4; pte = w; fin = 1; end
          else begin
            a = ((w & ~32'd3) << 4) +
                (lv == 0 ? {22'd0, va[31:24], 2'b0} :
                 lv == 1 ? {24'd0, va[23:18], 2'b0} : {24'd0, va[17:12], 2'b0});
            lv++;
          end
        end else begin
          if (lv == 0) begin e = 3'd4; pte = w; fin = 1; end
          else begin
            mask = (lv == 1) ? 32'h00FF_FFFF : (lv == 2) ? 32'h0003_FFFF : 32'h0000_0FFF;
            pa = ((w & 32'hFFFF_FF00) << 4) + (va & mask);
            nw = w | 32'h20 | (we ? 32'h40 : 32'h0);
            pte = nw;
            if (nw != w) begin nwr = 1; wba = a; wbv = nw; end
            fin = 1;
          end
        end
      end
    end
  endtask

  task automatic walk(input logic [31:0] va, input bit we, input bit en, input logic [7:0] ctx);
    logic [31:0] epa, epte, efa, ewba, ewbv;
    logic [2:0]  eerr;
    int enrd, enwr, n;
    if (en) ref_walk(va, we, cfg_root, ctx, epa, epte, eerr, enrd, enwr, efa, ewba, ewbv);
    else begin
      epa = va; epte = 0; eerr = 0; enrd = 0; enwr = 0; efa = 0; ewba = 0; ewbv = 0;
    end
    @(negedge clk);
    cfg_enable = en; cfg_ctx = ctx; vaddr = va; is_write = we; start = 1'b1;
    rd_cnt = 0; wr_cnt = 0; req_cnt = 0; first_pending = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    #1;
    check(done === 1'b1, "R9 done seen", {31'd0, done}, 32'd1);
    if (!en) begin
      check(n == 0, "R1 bypass latency", n, 0);
      check(req_cnt == 0, "R1 no memory request", req_cnt, 0);
      check(full_access === 1'b1, "R1 full_access", {31'd0, full_access}, 32'd1);
      check(paddr === epa, "R1 paddr", paddr, epa);
      check(err === 3'd0, "R1 err", {29'd0, err}, 32'd0);
    end else begin
      check(first_addr === efa, "R2 first read address", first_addr, efa);
      check(err === eerr, "R4 err code", {29'd0, err}, {29'd0, eerr});
      check(rd_cnt == enrd, "R5 read count", rd_cnt, enrd);
      check(paddr === epa, "R6 paddr", paddr, epa);
      check(pte_out === epte, "R7 R10 pte_out", pte_out, epte);
      check(wr_cnt == enwr, "R7 write-back count", wr_cnt, enwr);
      check(full_access === 1'b0, "R11 full_access", {31'd0, full_access}, 32'd0);
      if (enwr != 0)
        check(rd_word(ewba) === ewbv, "R3 R7 stored entry", rd_word(ewba), ewbv);
    end
    @(negedge clk);
    check(done === 1'b0, "R9 single pulse", {31'd0, done}, 32'd0);
    check(paddr === epa, "R9 result held", paddr, epa);
  endtask

  function automatic logic [31:0] mkpage(input logic [23:0] s, input logic [1:0] f);
    return {s, 1'b0, f[1], f[0], 3'b101, 2'b10};
  endfunction

  function automatic logic [31:0] mkptr(input logic [31:0] base);
    return (base >> 4) | 32'd1;
  endfunction

  task automatic build_tables();
    logic [31:0] w;
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    // context table at 0x400
    mem[(32'h400 + 0*16) >> 2] = bswap(mkptr(32'h800));
    mem[(32'h400 + 1*16) >> 2] = bswap(32'h0000_0000);
    mem[(32'h400 + 2*16) >> 2] = bswap(mkpage(24'h12345, 2'b00));
    mem[(32'h400 + 3*16) >> 2] = bswap(32'hABCD_EF03);
    mem[(32'h400 + 4*16) >> 2] = bswap(mkptr(32'h800));
    // first-level table at 0x800
    for (int j = 0; j < 256; j++) begin
      case (j % 5)
        0: w = {j[7:0], 24'h0};
        1: w = mkptr(32'hC00);
        2: w = mkptr(32'hD00);
        3: w = mkpage(24'(j * 32'h1357), j[1:0]);
        default: w = {j[7:0], 22'h0, 2'b11};
      endcase
      mem[(32'h800 >> 2) + j] = bswap(w);
    end
    // second-level tables at 0xC00 and 0xD00
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 64; i++) begin
        case ((i + b) % 5)
          0: w = 32'h0;
          1: w = mkptr(i[0] ? 32'hF00 : 32'hE00);
          2: w = mkpage(24'(i * 32'h2468 + b), i[2:1]);
          3: w = 32'h5555_5503;
          default: w = mkptr(32'hE00);
        endcase
        mem[((32'hC00 + b * 256) >> 2) + i] = bswap(w);
      end
    // third-level tables at 0xE00 and 0xF00
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 64; i++) begin
        case ((i + 2 * b) % 5)
          0: w = 32'h0;
          1: w = mkptr(32'hE00);
          2: w = mkpage(24'(i * 32'h0F0F1 + b), i[1:0]);
          3: w = 32'hFFFF_FF03;
          default: w = mkpage(24'(i * 32'h777), {i[0], 1'b1});
        endcase
        mem[((32'hE00 + b * 256) >> 2) + i] = bswap(w);
      end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] va;
    rst_n = 1'b0; start = 1'b0; cfg_enable = 1'b0; cfg_root = 28'h40; cfg_ctx = 8'd0;
    vaddr = 32'h0; is_write = 1'b0; mem_rdata = 32'h0;
    rd_cnt = 0; wr_cnt = 0; req_cnt = 0; first_pending = 1'b0; first_addr = 32'h0;
    build_tables();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(done === 1'b0, "R9 reset done", {31'd0, done}, 32'd0);
    check(mem_req === 1'b0, "R8 reset mem_req", {31'd0, mem_req}, 32'd0);

    // R1 bypass sweep
    for (int k = 0; k < 32; k++)
      walk(32'h9E37_79B9 * k + 32'h1000, k[0], 1'b0, 8'd0);

    // R2 R4 context-level outcomes
    for (int c = 1; c <= 3; c++)
      for (int k = 0; k < 4; k++)
        walk({k[7:0], 24'h12345}, k[0], 1'b1, c[7:0]);

    // R7 repeat walk: the second write sees flags already set
    walk(32'h0312_3456, 1'b1, 1'b1, 8'd0);
    walk(32'h0312_3456, 1'b1, 1'b1, 8'd0);

    // R3 R5 R6 R7 R10 sweep over every first-level index
    for (int c = 0; c < 2; c++)
      for (int j = 0; j < 256; j++)
        for (int s = 0; s < 4; s++) begin
          va = {j[7:0], 6'((s * 13 + j) % 64), 6'((s * 29 + j * 3) % 64),
                12'((j * 37 + s * 11) % 4096)};
          walk(va, s[0] ^ j[0], 1'b1, c == 0 ? 8'd0 : 8'd4);
        end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule